// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block collects eight level-sensitive interrupt request lines, numbered 8 to 15, and drives one encoded interrupt level, with an assert flag, to a CPU. Software assigns each line a 3-bit priority. It can block any line through a mask register. While at least one line is both requesting and unmasked, the block asserts its interrupt output. The level it reports is 8 plus the largest priority found among those active lines. Two lines that share a priority produce the same level.

Software reaches the registers over a plain synchronous register bus. The bus has a byte address, a write strobe, 16-bit write data and 16-bit combinational read data. Registers are selected by the byte address divided by four, so the two low address bits are ignored. The pending register mirrors the request inputs as they were captured on the last clock edge, and software cannot write it. Request lines are assumed to be synchronous to the block clock. The bus is a plain control port: a write lands on the edge where the strobe is high, and no handshake or back-pressure applies.

Top module: `irq_prio_ctrl`

## Requirements
- R1: On each clock edge, the pending register captures the level of every request line. Line n (8..15) appears at bit (15 - n) of the register read at byte offset 0x00. Line 8 is bit 7, line 15 is bit 0, and bits [15:8] read as zero.
- R2: A write to offset 0x00 leaves the pending register unchanged.
- R3: The mask register is at offset 0x40 and uses the same bit-per-line layout as the pending register. A mask bit of 1 blocks its line and 0 allows it. Only bits [7:0] are stored, and bits [15:8] read as zero.
- R4: The priority register at offset 0x80 holds the 3-bit priorities of lines 12, 13, 14 and 15 at bits [2:0], [5:3], [8:6] and [11:9]. The register at offset 0xC0 holds lines 8, 9, 10 and 11 in the same layout. Bits [15:12] of both read as zero.
- R5: A line is active when its pending bit is 1 and its mask bit is 0. When any line is active, irq_o is 1 and irq_level_o is 8 plus the largest priority among the active lines. Lines that tie on priority give that same level.
- R6: With no active line, irq_o is 0 and irq_level_o is 0.
- R7: After reset the mask reads 0x00FF, the pending register reads 0, both priority registers read 0 and irq_o is 0.
- R8: Register selection uses addr_i[7:2], so addr_i[1:0] are ignored. Any other offset reads 0, and a write to it changes no register.
- R9: A request change or register write captured on a clock edge shows on irq_o and irq_level_o straight after that edge. No further cycle of delay is added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | 8 | Request levels; bit k is line 8+k |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte address |
| wr_data_i | input | 16 | Register write data |
| rd_data_o | output | 16 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Interrupt asserted to the CPU |
| irq_level_o | output | 4 | 8 plus highest active priority, 0 when idle |

## Verification
The hardest case to reach from the ports is a winner decided by priority rather than line number. That case needs several lines requesting at once, with different mask holes and with priorities that are unordered, reversed or tied. The bench programs a series of priority permutations, including an all-equal set. For each one, it sweeps every one of the 256 request patterns against several masks and compares the level with a maximum computed in the bench. Separate directed steps cover readback layout, ignored writes and the two low address bits.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned IRQ_SRCS   = 8;
  localparam int unsigned PRIO_W     = 3;
  localparam int unsigned BUS_W      = 16;
  localparam int unsigned ADDR_W     = 8;
  localparam int unsigned LVL_W      = 4;
  localparam int unsigned BASE_LVL   = 8;
  localparam int unsigned FIELDS_PER = IRQ_SRCS / 2;
  localparam int unsigned WORD_W     = ADDR_W - 2;

  // word index = byte offset / 4
  localparam logic [WORD_W-1:0] PEND_WORD  = WORD_W'(8'h00 >> 2);
  localparam logic [WORD_W-1:0] MASK_WORD  = WORD_W'(8'h40 >> 2);
  localparam logic [WORD_W-1:0] PRIO0_WORD = WORD_W'(8'h80 >> 2);
  localparam logic [WORD_W-1:0] PRIO1_WORD = WORD_W'(8'hC0 >> 2);

  typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/irq_req_capture.sv
module irq_req_capture #(
  parameter int unsigned N = irq_pkg::IRQ_SRCS
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] pend_o
);
  // Level-following pending state, indexed by line (bit k = line 8+k)
  always_ff @(posedge clk_i) begin
    if (!rst_ni) pend_o <= '0;
    else         pend_o <= req_i;
  end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_pkg::*;
#(
  parameter int unsigned N = IRQ_SRCS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wr_data_i,
  input  logic [N-1:0]      pend_i,
  output logic [BUS_W-1:0]  rd_data_o,
  output logic [N-1:0]      mask_o,
  output prio_t             prio_o [N]
);
  localparam int unsigned HALF = N / 2;

  logic [WORD_W-1:0] word;
  logic [N-1:0]      pend_view;
  logic [N-1:0]      mask_view;
  logic [N-1:0]      wr_mask_line;
  logic [BUS_W-1:0]  prio0_view;
  logic [BUS_W-1:0]  prio1_view;

  assign word = addr_i[ADDR_W-1:2];

  // register view puts line 8+k at bit N-1-k
  for (genvar k = 0; k < N; k++) begin : g_rev
    assign pend_view[N-1-k]    = pend_i[k];
    assign mask_view[N-1-k]    = mask_o[k];
    assign wr_mask_line[k]     = wr_data_i[N-1-k];
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) mask_o <= '1;
    else if (wr_en_i && word == MASK_WORD) mask_o <= wr_mask_line;
  end

  for (genvar k = 0; k < N; k++) begin : g_prio
    localparam int unsigned FLD = k % HALF;
    localparam logic [WORD_W-1:0] SEL = (k >= HALF) ? PRIO0_WORD : PRIO1_WORD;
    always_ff @(posedge clk_i) begin
      if (!rst_ni) prio_o[k] <= '0;
      else if (wr_en_i && word == SEL) prio_o[k] <= wr_data_i[FLD*PRIO_W +: PRIO_W];
    end
  end

  always_comb begin
    prio0_view = '0;
    prio1_view = '0;
    for (int f = 0; f < int'(HALF); f++) begin
      prio0_view[f*PRIO_W +: PRIO_W] = prio_o[HALF + f];
      prio1_view[f*PRIO_W +: PRIO_W] = prio_o[f];
    end
  end

  always_comb begin
    unique case (word)
      PEND_WORD:  rd_data_o = BUS_W'(pend_view);
      MASK_WORD:  rd_data_o = BUS_W'(mask_view);
      PRIO0_WORD: rd_data_o = prio0_view;
      PRIO1_WORD: rd_data_o = prio1_view;
      default:    rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_level_resolver.sv
module irq_level_resolver
  import irq_pkg::*;
#(
  parameter int unsigned N = IRQ_SRCS
) (
  input  logic [N-1:0]     active_i,
  input  prio_t            prio_i [N],
  output logic             irq_o,
  output logic [LVL_W-1:0] level_o
);
  // Running maximum carried through a chain of compare stages
  logic  found [N+1];
  prio_t best  [N+1];

  assign found[0] = 1'b0;
  assign best[0]  = '0;

  for (genvar k = 0; k < N; k++) begin : g_stage
    logic take;
    assign take        = active_i[k] && (!found[k] || prio_i[k] >= best[k]);
    assign found[k+1]  = found[k] | active_i[k];
    assign best[k+1]   = take ? prio_i[k] : best[k];
  end

  assign irq_o   = found[N];
  assign level_o = found[N] ? (LVL_W'(BASE_LVL) + LVL_W'(best[N])) : '0;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned N = IRQ_SRCS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      req_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wr_data_i,
  output logic [BUS_W-1:0]  rd_data_o,
  output logic              irq_o,
  output logic [LVL_W-1:0]  irq_level_o
);
  logic [N-1:0] pend_line;
  logic [N-1:0] mask_line;
  logic [N-1:0] active;
  prio_t        prio_line [N];

  irq_req_capture #(.N(N)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .pend_o (pend_line)
  );

  irq_cfg_regs #(.N(N)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wr_data_i (wr_data_i),
    .pend_i    (pend_line),
    .rd_data_o (rd_data_o),
    .mask_o    (mask_line),
    .prio_o    (prio_line)
  );

  assign active = pend_line & ~mask_line;

  irq_level_resolver #(.N(N)) u_res (
    .active_i (active),
    .prio_i   (prio_line),
    .irq_o    (irq_o),
    .level_o  (irq_level_o)
  );
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk
  import irq_pkg::*;
#(
  parameter int unsigned N = IRQ_SRCS
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N-1:0]      req_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [BUS_W-1:0]  wr_data_i,
  input logic [N-1:0]      pend_line,
  input logic [N-1:0]      mask_line,
  input logic              irq_o,
  input logic [LVL_W-1:0]  irq_level_o
);
  function automatic logic [N-1:0] rev(input logic [N-1:0] v);
    for (int i = 0; i < int'(N); i++) rev[i] = v[N-1-i];
  endfunction

  // R1
  pending_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> pend_line == $past(req_i));

  // R3
  mask_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i[ADDR_W-1:2] == MASK_WORD) |=> mask_line == rev($past(wr_data_i[N-1:0])));

  // R5
  irq_when_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (|(pend_line & ~mask_line)));

  // R5
  level_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_level_o >= LVL_W'(BASE_LVL));

  // R6
  idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> irq_level_o == '0);

  // R7
  reset_mask_chk: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (mask_line == '1 && !irq_o));
endmodule

bind irq_prio_ctrl irq_prio_chk #(.N(N)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .wr_en_i     (wr_en_i),
  .addr_i      (addr_i),
  .wr_data_i   (wr_data_i),
  .pend_line   (pend_line),
  .mask_line   (mask_line),
  .irq_o       (irq_o),
  .irq_level_o (irq_level_o)
);

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  req = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  logic [3:0]  lvl;

  int n_vec = 0;
  int n_bad = 0;
  logic [2:0] model_prio [8];
  logic [7:0] model_mask;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_en_i(wr_en),
    .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rdata),
    .irq_o(irq), .irq_level_o(lvl)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction

  // bit k of req/mask_line is line 8+k
  task automatic set_prios(input int a, input int b);
    logic [15:0] r0, r1;
    r0 = '0; r1 = '0;
    for (int k = 0; k < 8; k++) model_prio[k] = 3'((k*a + b) % 8);
    for (int f = 0; f < 4; f++) begin
      r1[f*3 +: 3] = model_prio[f];
      r0[f*3 +: 3] = model_prio[4+f];
    end
    wr(8'h80, r0 | 16'hF000);
    wr(8'hC0, r1 | 16'hF000);
  endtask

  task automatic expect_out(input logic [7:0] r, input string tag);
    int best;
    best = -1;
    for (int k = 0; k < 8; k++)
      if (r[k] && !model_mask[k] && int'(model_prio[k]) > best) best = int'(model_prio[k]);
    check({tag, " irq"}, int'(irq), best >= 0 ? 1 : 0);
    check({tag, " level"}, int'(lvl), best >= 0 ? 8 + best : 0);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    logic [15:0] d;
    int pa [6];
    int pb [6];
    logic [7:0] masks [5];
    pa = '{1, 3, 5, 7, 0, 1};
    pb = '{0, 2, 7, 1, 4, 3};
    masks = '{8'h00, 8'h55, 8'hA0, 8'h0F, 8'hFF};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R7 reset state
    rd(8'h40, d); check("R7 mask", d, 16'h00FF);
    rd(8'h00, d); check("R7 pending", d, 0);
    rd(8'h80, d); check("R7 prio0", d, 0);
    rd(8'hC0, d); check("R7 prio1", d, 0);
    check("R7 irq", irq, 0);

    // R1 pending layout: line 8 -> bit7, line 15 -> bit0
    @(negedge clk); req = 8'b0000_0001;
    @(negedge clk); addr = 8'h00; #1 check("R1 line8", rdata, 16'h0080);
    req = 8'b1000_0010;
    @(negedge clk); #1 check("R1 lines9,15", rdata, 16'h0041);
    check("R6 masked out irq", irq, 0);

    // R2 pending write ignored
    wr(8'h00, 16'hFFFF);
    rd(8'h00, d); check("R2 pending", d, 16'h0041);
    req = 8'h00;
    @(negedge clk); #1 check("R1 cleared", rdata, 0);

    // R3 mask layout, upper bits dropped
    wr(8'h40, 16'hFF5A);
    rd(8'h40, d); check("R3 mask readback", d, 16'h005A);
    // R8 low address bits ignored
    rd(8'h43, d); check("R8 low bits", d, 16'h005A);

    // R4 priority layout
    wr(8'h80, 16'hFFFF);
    rd(8'h80, d); check("R4 prio0 upper", d, 16'h0FFF);
    wr(8'h80, 16'h0A3C);
    wr(8'hC0, 16'h0531);
    rd(8'h81, d); check("R4 prio0", d, 16'h0A3C);
    rd(8'hC2, d); check("R4 prio1", d, 16'h0531);

    // R8 unmapped: read zero, write touches nothing
    wr(8'h20, 16'hFFFF);
    wr(8'hFC, 16'hFFFF);
    rd(8'h20, d); check("R8 unmapped read", d, 0);
    rd(8'h40, d); check("R8 mask kept", d, 16'h005A);
    rd(8'h80, d); check("R8 prio0 kept", d, 16'h0A3C);
    rd(8'hC0, d); check("R8 prio1 kept", d, 16'h0531);

    // R9 timing: line 15 (prio field 0A3C[11:9]=5) unmasked
    wr(8'h40, 16'h0000);
    @(negedge clk); req = 8'h80;
    check("R9 before edge", irq, 0);
    @(negedge clk); check("R9 after edge level", lvl, 13);
    // R9 mask write takes effect after its edge
    @(negedge clk); wr_en = 1'b1; addr = 8'h40; wdata = 16'h0001;
    check("R9 pre-mask", irq, 1);
    @(negedge clk); wr_en = 1'b0;
    check("R9 masked", irq, 0);
    req = 8'h00;

    // R5/R6 sweeps over priority sets, masks, all request patterns
    for (int p = 0; p < 6; p++) begin
      set_prios(pa[p], pb[p]); // p=4 gives all-equal (tie)
      for (int m = 0; m < 5; m++) begin
        model_mask = masks[m];
        wr(8'h40, {8'h00, rev8(model_mask)});
        for (int r = 0; r < 256; r++) begin
          @(negedge clk); req = 8'(r);
          @(negedge clk);
          expect_out(8'(r), m == 4 ? "R6 all masked" : "R5 sweep");
        end
      end
    end

    req = '0;
    @(negedge clk); @(negedge clk);
    check("R6 idle irq", irq, 0);
    check("R6 idle level", lvl, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule